// File: doc/BRIEF.md
# Fixed-Latency Instruction Fetch Sequencer

This block fetches one instruction word over a single clocked bus that it shares with a memory of fixed access time. It owns three registers: a program counter, a memory address register and an instruction register. It moves the program counter value to memory over the bus. It waits out the memory's known latency. It then captures the returned word into the instruction register. Every bus enable and every register load strobe comes from a small sequencer, one micro-operation per clock.

The memory latency `LAT` is a parameter with a default of 3. No ready handshake exists: the data slot is fixed at exactly `LAT` cycles after the address slot. The program counter advances by one during the wait, with no bus use. A fetch takes `LAT + 1` cycles. If a request is waiting when a fetch ends, the next fetch follows with no idle cycle.

The unit drives `bus_drv` and asserts `addr_oe` when it owns the bus. It asserts `mem_oe` when memory must drive. The resolved bus value comes back on `bus_in`. Logic outside the block merges the two sources.

Top module: `fetch_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the unit returns to idle. After that edge, `pc` equals `RST_VEC`, `mar` and `ir` are zero, and `addr_oe`, `mem_oe` and `done` are low.
- R2: In idle with `fetch_req` low, no enable or `done` is asserted, and `pc`, `mar` and `ir` hold their values.
- R3: A fetch starts in the cycle after an edge that sees `fetch_req` high in idle. That cycle is the address cycle. `addr_oe` is high for that single cycle only, and `bus_drv` carries `pc` zero-extended. `mar` loads `bus_in[AW-1:0]` at the end of the address cycle.
- R4: `mem_oe` is high for exactly one cycle, and that cycle is exactly `LAT` cycles after the address cycle.
- R5: At the end of the `mem_oe` cycle, `ir` loads `bus_in`. `done` is high in that same cycle and in no other.
- R6: Between the address cycle and the data cycle, `addr_oe` and `mem_oe` are both low. `pc` increments once per fetch, at the end of the first wait cycle (at the end of the data cycle when `LAT` is 1). After each fetch, `pc` equals `mar + 1`.
- R7: `addr_oe` and `mem_oe` are never high in the same cycle.
- R8: One fetch occupies `LAT + 1` cycles. If `fetch_req` is high in the data cycle, the next cycle is a new address cycle. Otherwise the unit returns to idle.
- R9: `bus_drv` is zero in every cycle in which `addr_oe` is low.
- R10: `pc` wraps modulo 2^`AW` (255 + 1 gives 0 with `AW` = 8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req | input | 1 | Level request for a fetch, sampled in idle and in the data cycle |
| bus_in | input | DW | Resolved value of the shared bus |
| addr_oe | output | 1 | Unit drives the program counter onto the bus this cycle |
| mem_oe | output | 1 | Memory must drive the instruction onto the bus this cycle |
| bus_drv | output | DW | Value the unit places on the bus (zero when not driving) |
| done | output | 1 | One-cycle pulse in the cycle the instruction register loads |
| pc | output | AW | Program counter |
| mar | output | AW | Memory address register |
| ir | output | DW | Instruction register |

## Verification
The assertions assume that `bus_in` equals `bus_drv` whenever `addr_oe` is high. They also assume that `bus_in` equals the memory word whenever `mem_oe` is high. They assume that `fetch_req` is a level signal that is only looked at in idle and in the data cycle. The bench meets these conditions with a combinational bus merge that follows the two enables. Its memory model captures the address from the bus in the address cycle and answers only when `mem_oe` is high, with a word that is an arithmetic function of the address. Requests are changed only on falling edges. The sweep covers isolated fetches, a back-to-back run long enough to wrap the program counter, and a reset in the middle of a wait.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_ADDR = 2'd1,
        FS_WAIT = 2'd2,
        FS_DATA = 2'd3
    } fstate_e;

    // one micro-operation word per cycle
    typedef struct packed {
        logic addr_oe;
        logic mem_oe;
        logic mar_ld;
        logic ir_ld;
        logic pc_inc;
    } uop_t;

    function automatic uop_t decode_uop(input fstate_e s, input logic inc_slot);
        uop_t u;
        u.addr_oe = (s == FS_ADDR);
        u.mar_ld  = (s == FS_ADDR);
        u.mem_oe  = (s == FS_DATA);
        u.ir_ld   = (s == FS_DATA);
        u.pc_inc  = inc_slot;
        return u;
    endfunction

    function automatic fstate_e after_data(input logic req);
        return req ? FS_ADDR : FS_IDLE;
    endfunction

endpackage

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
    import fetch_pkg::*;
#(
    parameter int LAT = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic fetch_req,
    output uop_t uop_o
);

    localparam int CW  = (LAT < 2) ? 1 : $clog2(LAT);
    localparam int SW  = $clog2(LAT + 1);

    fstate_e       state;
    logic [CW-1:0] wcnt;
    logic          inc_slot;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= FS_IDLE;
            wcnt  <= '0;
        end else begin
            case (state)
                FS_IDLE: if (fetch_req) state <= FS_ADDR;
                FS_ADDR: begin
                    if (LAT == 1) begin
                        state <= FS_DATA;
                    end else begin
                        state <= FS_WAIT;
                        wcnt  <= CW'(1);
                    end
                end
                FS_WAIT: begin
                    if (wcnt == CW'(LAT - 1)) state <= FS_DATA;
                    else                      wcnt  <= wcnt + 1'b1;
                end
                FS_DATA: state <= after_data(fetch_req);
                default: state <= FS_IDLE;
            endcase
        end
    end

    generate
        if (LAT == 1) begin : g_inc_data
            assign inc_slot = (state == FS_DATA);
        end else begin : g_inc_wait
            assign inc_slot = (state == FS_WAIT) && (wcnt == CW'(1));
        end
    endgenerate

    assign uop_o = decode_uop(state, inc_slot);

    // cycles since the last address slot, kept apart from the wait counter
    logic [SW-1:0] since_addr;
    always_ff @(posedge clk) begin
        if (rst)                                          since_addr <= '0;
        else if (uop_o.addr_oe)                           since_addr <= SW'(1);
        else if (since_addr != '0 && since_addr != SW'(LAT)) since_addr <= since_addr + 1'b1;
        else                                              since_addr <= '0;
    end

    // R7
    no_bus_clash_chk: assert property (@(posedge clk) disable iff (rst)
        !(uop_o.addr_oe && uop_o.mem_oe));

    // R4
    data_slot_chk: assert property (@(posedge clk) disable iff (rst)
        uop_o.mem_oe |-> since_addr == SW'(LAT));

    // R4
    data_due_chk: assert property (@(posedge clk) disable iff (rst)
        since_addr == SW'(LAT) |-> uop_o.mem_oe);

endmodule

// File: rtl/fetch_regs.sv
module fetch_regs #(
    parameter int             AW      = 8,
    parameter int             DW      = 16,
    parameter logic [AW-1:0]  RST_VEC = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          addr_oe,
    input  logic          mar_ld,
    input  logic          ir_ld,
    input  logic          pc_inc,
    input  logic [DW-1:0] bus_in,
    output logic [DW-1:0] bus_drv,
    output logic [AW-1:0] pc_q,
    output logic [AW-1:0] mar_q,
    output logic [DW-1:0] ir_q
);

    assign bus_drv = addr_oe ? DW'(pc_q) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= RST_VEC;
            mar_q <= '0;
            ir_q  <= '0;
        end else begin
            if (mar_ld) mar_q <= bus_in[AW-1:0];
            if (ir_ld)  ir_q  <= bus_in;
            if (pc_inc) pc_q  <= pc_q + 1'b1;
        end
    end

    // R6
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        ir_ld |=> pc_q == mar_q + 1'b1);

endmodule

// File: rtl/fetch_seq.sv
module fetch_seq
    import fetch_pkg::*;
#(
    parameter int             AW      = 8,
    parameter int             DW      = 16,
    parameter int             LAT     = 3,
    parameter logic [AW-1:0]  RST_VEC = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fetch_req,
    input  logic [DW-1:0] bus_in,
    output logic          addr_oe,
    output logic          mem_oe,
    output logic [DW-1:0] bus_drv,
    output logic          done,
    output logic [AW-1:0] pc,
    output logic [AW-1:0] mar,
    output logic [DW-1:0] ir
);

    uop_t uop;

    fetch_ctrl #(.LAT(LAT)) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .fetch_req (fetch_req),
        .uop_o     (uop)
    );

    fetch_regs #(.AW(AW), .DW(DW), .RST_VEC(RST_VEC)) regs_i (
        .clk     (clk),
        .rst     (rst),
        .addr_oe (uop.addr_oe),
        .mar_ld  (uop.mar_ld),
        .ir_ld   (uop.ir_ld),
        .pc_inc  (uop.pc_inc),
        .bus_in  (bus_in),
        .bus_drv (bus_drv),
        .pc_q    (pc),
        .mar_q   (mar),
        .ir_q    (ir)
    );

    assign addr_oe = uop.addr_oe;
    assign mem_oe  = uop.mem_oe;
    assign done    = uop.ir_ld;

    // R3
    addr_once_chk: assert property (@(posedge clk) disable iff (rst)
        addr_oe |=> !addr_oe);

    // R5
    done_with_data_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> mem_oe && !addr_oe);

    // R9
    quiet_drv_chk: assert property (@(posedge clk) disable iff (rst)
        !addr_oe |-> bus_drv == '0);

endmodule

// File: tb/fetch_seq_tb_top.sv
`timescale 1ns/1ps
module fetch_seq_tb_top;

    localparam int AW  = 8;
    localparam int DW  = 16;
    localparam int LAT = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          fetch_req = 1'b0;
    logic [DW-1:0] bus_in;
    logic          addr_oe, mem_oe, done;
    logic [DW-1:0] bus_drv;
    logic [AW-1:0] pc, mar;
    logic [DW-1:0] ir;

    logic [AW-1:0] mem_addr = '0;
    logic [AW-1:0] pc_exp   = '0;
    int            errors   = 0;
    int            checks   = 0;

    always #2.5 clk = ~clk;

    function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
        return {a ^ 8'hA5, a + 8'd17};
    endfunction

    // memory: latches the address from the bus, answers only on mem_oe
    always @(posedge clk) if (addr_oe) mem_addr <= bus_in[AW-1:0];
    assign bus_in = addr_oe ? bus_drv : (mem_oe ? memf(mem_addr) : '0);

    fetch_seq #(.AW(AW), .DW(DW), .LAT(LAT), .RST_VEC(8'h00)) dut_i (
        .clk(clk), .rst(rst), .fetch_req(fetch_req), .bus_in(bus_in),
        .addr_oe(addr_oe), .mem_oe(mem_oe), .bus_drv(bus_drv), .done(done),
        .pc(pc), .mar(mar), .ir(ir)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // R7 monitored on every cycle
    always @(negedge clk) if (!rst)
        check(!(addr_oe && mem_oe), "R7 two bus drivers", {addr_oe, mem_oe}, 0);

    task automatic check_idle(input logic [DW-1:0] ir_hold);
        check(!addr_oe && !mem_oe && !done, "R2 idle enables", {addr_oe, mem_oe, done}, 0);
        check(pc == pc_exp, "R2 pc holds", pc, pc_exp);
        check(ir == ir_hold, "R2 ir holds", ir, ir_hold);
        check(bus_drv == '0, "R9 bus_drv quiet", bus_drv, 0);
    endtask

    // called at the falling edge inside an address cycle
    task automatic fetch_one(input bit keep);
        check(addr_oe == 1'b1, "R3 address cycle", addr_oe, 1);
        check(bus_drv == DW'(pc_exp), "R3 bus_drv carries pc", bus_drv, pc_exp);
        fetch_req = keep;
        for (int k = 1; k < LAT; k++) begin
            @(negedge clk);
            check(!addr_oe && !mem_oe, "R6 bus idle in wait", {addr_oe, mem_oe}, 0);
            check(!done, "R5 no done in wait", done, 0);
            check(bus_drv == '0, "R9 bus_drv quiet in wait", bus_drv, 0);
        end
        @(negedge clk);
        check(mem_oe == 1'b1, "R4 data slot at LAT", mem_oe, 1);
        check(done == 1'b1, "R5 done in data cycle", done, 1);
        if (LAT > 1)
            check(pc == pc_exp + 1'b1, "R6 pc stepped in wait", pc, pc_exp + 1'b1);
        @(negedge clk);
        check(ir == memf(pc_exp), "R5 ir loaded", ir, memf(pc_exp));
        check(mar == pc_exp, "R3 mar loaded", mar, pc_exp);
        check(pc == AW'(pc_exp + 1'b1), "R10 pc after fetch", pc, AW'(pc_exp + 1'b1));
        check(!done && !mem_oe, "R5 done single cycle", {done, mem_oe}, 0);
        check(addr_oe == keep, "R8 next cycle follows request", addr_oe, keep);
        pc_exp = pc_exp + 1'b1;
    endtask

    initial begin
        #(5.0 * 150000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(pc == 8'h00 && mar == '0 && ir == '0, "R1 reset registers", {pc, mar}, 0);
        check(!addr_oe && !mem_oe && !done, "R1 reset enables", {addr_oe, mem_oe, done}, 0);
        rst = 1'b0;
        repeat (4) begin @(negedge clk); check_idle('0); end

        // isolated fetches with gaps
        for (int n = 0; n < 3; n++) begin
            fetch_req = 1'b1;
            @(negedge clk);
            fetch_one(1'b0);
            repeat (3) begin @(negedge clk); check_idle(memf(pc_exp - 1'b1)); end
        end

        // back-to-back run that wraps the program counter (R8, R10)
        fetch_req = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 260; i++) fetch_one(i < 259);
        check(pc == 8'd7, "R10 wrapped pc", pc, 7);
        repeat (2) begin @(negedge clk); check_idle(memf(pc_exp - 1'b1)); end

        // reset in the middle of a wait
        fetch_req = 1'b1;
        @(negedge clk);
        fetch_req = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(pc == 8'h00 && mar == '0 && ir == '0, "R1 reset mid fetch", {pc, mar}, 0);
        check(!addr_oe && !mem_oe && !done, "R1 enables after reset", {addr_oe, mem_oe, done}, 0);
        rst = 1'b0;
        pc_exp = '0;
        @(negedge clk);
        check_idle('0);

        // recovery fetch
        fetch_req = 1'b1;
        @(negedge clk);
        fetch_one(1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule